// File: doc/BRIEF.md
# Two-Wire SCL Phase Timing Generator

This block derives the SCL waveform for a two-wire bus master from the system clock. A single configuration word carries two 8-bit divisors and a 3-bit power-of-two prescaler exponent. One divisor sets the low phase and the other sets the high phase, so the clock may run with an even or an uneven duty cycle. Each phase lasts the divisor shifted left by the exponent plus a fixed build-time offset, counted in system clocks.

The bit-level master drives `run` while it wants the bus clocked and can raise `hold` to freeze the waveform, for example while a target stretches the clock. The generator produces the SCL level and two single-cycle strobes. One strobe marks the end of each low phase, where SDA may change. The other marks the end of each high phase, where SDA is sampled. A new configuration is held in a shadow register and is only taken up when a phase begins, so a phase in progress keeps its length.

Top module: `scl_wave_gen`

## Requirements
- R1: While `run` is low, from the first clock edge that samples it low, `scl_o` is 1 and both strobes are 0.
- R2: The configuration word is decoded as follows: low divisor in bits 7:0, high divisor in bits 15:8, exponent in bits 18:16. Bits 31:19 have no effect on the waveform.
- R3: A phase with divisor d and effective exponent e lasts d·2^e + OFFSET clock cycles, counting only cycles in which `hold` is low. OFFSET is a parameter, 3 or 4, with a default of 4.
- R4: After `run` rises, the waveform starts with a low phase (`scl_o` = 0). Low and high phases then alternate for as long as `run` stays high.
- R5: `low_end` is high for exactly one cycle, the last cycle of each low phase. `high_end` is high for exactly one cycle, the last cycle of each high phase. The two strobes are never high together.
- R6: An exponent field above the EXP_MAX parameter (5 or 7, default 5) acts as EXP_MAX.
- R7: A divisor of zero gives a phase of exactly OFFSET cycles.
- R8: A configuration write made during a phase leaves that phase's length unchanged. The new values apply from the next phase that starts.
- R9: While `hold` is high during a running phase, `scl_o` stays constant, no strobe is given, and the phase counter does not advance.
- R10: If `run` drops in the middle of a phase, the counters reset. The next rise of `run` begins a complete fresh low phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | DATA_W (32) | Configuration word: low divisor, high divisor, exponent |
| run | input | 1 | Master requests SCL activity |
| hold | input | 1 | Freeze the current phase (clock stretch) |
| scl_o | output | 1 | SCL level, 1 = released/high |
| low_end | output | 1 | Strobe in the final cycle of a low phase |
| high_end | output | 1 | Strobe in the final cycle of a high phase |

## Verification
The bench drives inputs just after a rising edge and samples on falling edges. When `run` is raised, the first low-phase cycle becomes visible at the falling edge after the second rising edge. From that point each phase is measured as a run of equal `scl_o` samples. The matching strobe is expected on the last sample of the run, and no strobe on any other sample. A configuration write takes two rising edges to reach the shadow register, so writes meant to land mid-phase are made well inside phases of at least eight cycles. When `run` is dropped, `scl_o` is expected high at the falling edge after the next rising edge.

// File: rtl/scl_wave_pkg.sv
package scl_wave_pkg;

  localparam int DIV_W   = 8;
  localparam int EXP_W   = 3;
  localparam int LO_LSB  = 0;
  localparam int HI_LSB  = 8;
  localparam int EXP_LSB = 16;

  typedef enum logic {
    PH_LOW  = 1'b0,
    PH_HIGH = 1'b1
  } scl_phase_e;

  typedef struct packed {
    logic [EXP_W-1:0] exp;
    logic [DIV_W-1:0] hi_div;
    logic [DIV_W-1:0] lo_div;
  } scl_cfg_t;

endpackage

// File: rtl/scl_cfg_reg.sv
module scl_cfg_reg
  import scl_wave_pkg::*;
#(
  parameter int EXP_MAX = 5,
  parameter int DATA_W  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [DATA_W-1:0] wdata,
  output scl_cfg_t          cfg
);

  localparam logic [EXP_W-1:0] EXP_CAP = EXP_W'(EXP_MAX);
  localparam int TOP_USED = EXP_LSB + EXP_W;

  function automatic scl_cfg_t decode(input logic [DATA_W-1:0] w);
    scl_cfg_t         c;
    logic [EXP_W-1:0] raw;
    raw      = w[EXP_LSB +: EXP_W];
    c.lo_div = w[LO_LSB +: DIV_W];
    c.hi_div = w[HI_LSB +: DIV_W];
    c.exp    = (raw > EXP_CAP) ? EXP_CAP : raw;
    return c;
  endfunction

  scl_cfg_t cfg_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  cfg_q <= '0;
    else if (we) cfg_q <= decode(wdata);
  end

  assign cfg = cfg_q;

  logic unused_hi_bits;
  assign unused_hi_bits = ^wdata[DATA_W-1:TOP_USED];

  // R2: each divisor field lands in its own slot
  p_field_slots_r2: assert property (@(posedge clk) disable iff (!rst_n)
    we |=> (cfg.lo_div == $past(wdata[LO_LSB +: DIV_W])) &&
           (cfg.hi_div == $past(wdata[HI_LSB +: DIV_W])));

  // R6: oversized exponent is clamped
  p_exp_clamp_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (we && (wdata[EXP_LSB +: EXP_W] > EXP_CAP)) |=> (cfg.exp == EXP_CAP));

endmodule

// File: rtl/scl_phase_timer.sv
module scl_phase_timer #(
  parameter int LEN_W = 14
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic             enable,
  input  logic [LEN_W-1:0] len_in,
  output logic             at_last
);

  logic [LEN_W-1:0] cnt_q;
  logic [LEN_W-1:0] len_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      len_q <= LEN_W'(1);
    end else if (load) begin
      cnt_q <= '0;
      len_q <= len_in;
    end else if (enable) begin
      cnt_q <= cnt_q + LEN_W'(1);
    end
  end

  assign at_last = (cnt_q == (len_q - LEN_W'(1)));

  // R3: the count never runs past the loaded phase length
  p_cnt_in_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q < len_q);

  // R9: a frozen count keeps its value
  p_cnt_frozen_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && !enable) |=> $stable(cnt_q));

endmodule

// File: rtl/scl_wave_gen.sv
module scl_wave_gen
  import scl_wave_pkg::*;
#(
  parameter int OFFSET  = 4,
  parameter int EXP_MAX = 5,
  parameter int DATA_W  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [DATA_W-1:0] cfg_wdata,
  input  logic              run,
  input  logic              hold,
  output logic              scl_o,
  output logic              low_end,
  output logic              high_end
);

  localparam int LEN_W = DIV_W + EXP_MAX + 1;
  localparam logic [LEN_W-1:0] MAX_LEN =
    (LEN_W'((1 << DIV_W) - 1) << EXP_MAX) + LEN_W'(OFFSET);

  // phase length = divisor scaled by the prescaler, plus the fixed offset
  function automatic logic [LEN_W-1:0] phase_len(input logic [DIV_W-1:0] div,
                                                 input logic [EXP_W-1:0] e);
    return (LEN_W'(div) << e) + LEN_W'(OFFSET);
  endfunction

  scl_cfg_t         cfg;
  scl_phase_e       phase_q, phase_nxt;
  logic             running_q;
  logic             active, advance, phase_done, at_last, load;
  logic [LEN_W-1:0] lo_len, hi_len, next_len;

  scl_cfg_reg #(
    .EXP_MAX(EXP_MAX),
    .DATA_W (DATA_W)
  ) i_cfg (
    .clk  (clk),
    .rst_n(rst_n),
    .we   (cfg_we),
    .wdata(cfg_wdata),
    .cfg  (cfg)
  );

  assign lo_len = phase_len(cfg.lo_div, cfg.exp);
  assign hi_len = phase_len(cfg.hi_div, cfg.exp);

  assign active     = running_q & run;
  assign advance    = active & ~hold;
  assign phase_done = advance & at_last;

  always_comb begin
    if (!active)         phase_nxt = PH_LOW;
    else if (phase_done) phase_nxt = (phase_q == PH_LOW) ? PH_HIGH : PH_LOW;
    else                 phase_nxt = phase_q;
  end

  assign load     = ~active | phase_done;
  assign next_len = (phase_nxt == PH_HIGH) ? hi_len : lo_len;

  scl_phase_timer #(
    .LEN_W(LEN_W)
  ) i_timer (
    .clk    (clk),
    .rst_n  (rst_n),
    .load   (load),
    .enable (advance),
    .len_in (next_len),
    .at_last(at_last)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      running_q <= 1'b0;
      phase_q   <= PH_LOW;
    end else begin
      running_q <= run;
      phase_q   <= phase_nxt;
    end
  end

  assign scl_o    = ~(running_q & (phase_q == PH_LOW));
  assign low_end  = phase_done & (phase_q == PH_LOW);
  assign high_end = phase_done & (phase_q == PH_HIGH);

  // R1: idle keeps SCL released with no strobes
  p_idle_released_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (scl_o && !low_end && !high_end));

  // R5: strobes are mutually exclusive
  p_strobe_excl_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({low_end, high_end}));

  // R4: end of low phase hands over to high, end of high hands over to low
  p_low_to_high_r4: assert property (@(posedge clk) disable iff (!rst_n)
    low_end |=> scl_o);
  p_high_to_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
    high_end |=> !scl_o);

  // R8: no level change inside a phase
  p_no_midphase_flip_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (active && !phase_done) |=> $stable(scl_o));

  // R9: hold freezes the level and suppresses strobes
  p_hold_freeze_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (hold && active) |=> $stable(scl_o));
  p_hold_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    hold |-> (!low_end && !high_end));

  // R6: the selected length never exceeds the clamped maximum
  p_len_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
    next_len <= MAX_LEN);

endmodule

// File: tb/test_scl_wave_gen.sv
module test_scl_wave_gen;

  localparam int OFF  = 4;
  localparam int EXPM = 5;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [31:0] cfg_wdata = '0;
  logic        run = 1'b0;
  logic        hold = 1'b0;
  logic        scl_o, low_end, high_end;

  int tests = 0;
  int fails = 0;

  always #5 clk = ~clk;

  scl_wave_gen #(.OFFSET(OFF), .EXP_MAX(EXPM), .DATA_W(32)) i_scl_wave_gen (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .run(run), .hold(hold), .scl_o(scl_o), .low_end(low_end), .high_end(high_end)
  );

  function automatic int len_f(input int d, input int e);
    int ee;
    ee = (e > EXPM) ? EXPM : e;
    return d * (1 << ee) + OFF;
  endfunction

  function automatic logic [31:0] mk(input int lo, input int hi, input int e,
                                     input logic [31:0] junk);
    return (junk & 32'hFFF8_0000) | 32'((e & 7) << 16) | 32'((hi & 255) << 8) | 32'(lo & 255);
  endfunction

  task automatic check(input bit ok, input string tag, input string what,
                       input int act, input int expv);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, expv);
    end
  endtask

  task automatic write_cfg(input logic [31:0] v);
    @(posedge clk); #1;
    cfg_we = 1'b1; cfg_wdata = v;
    @(posedge clk); #1;
    cfg_we = 1'b0;
  endtask

  task automatic start_run();
    @(posedge clk); #1 run = 1'b1;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic stop_run();
    @(posedge clk); #1 run = 1'b0;
    @(posedge clk);
    @(negedge clk);
    check(scl_o == 1'b1 && !low_end && !high_end, "R1", "scl after stop",
          int'(scl_o), 1);
  endtask

  task automatic expect_phase(input bit lvl, input int len, input string tag);
    int n = 0;
    int bad = 0;
    while (scl_o == lvl && n < len + 8) begin
      bit want = (n == len - 1);
      bit got  = lvl ? high_end : low_end;
      bit oth  = lvl ? low_end : high_end;
      if (got != want || oth) bad++;
      n++;
      @(negedge clk);
    end
    check(n == len, tag, lvl ? "high phase length" : "low phase length", n, len);
    check(bad == 0, "R5", "strobe mismatches", bad, 0);
  endtask

  task automatic idle_watch(input int cycles);
    int bad = 0;
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk);
      if (!scl_o || low_end || high_end) bad++;
    end
    check(bad == 0, "R1", "idle samples off", bad, 0);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    fails++;
    tests++;
    $display("FAIL R3 watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    check(scl_o == 1'b1 && !low_end && !high_end, "R1", "reset state", int'(scl_o), 1);

    // idle with writes: nothing moves (R1)
    fork
      idle_watch(20);
      write_cfg(mk(7, 7, 2, 32'h0));
    join

    // symmetric-free basic pattern (R3, R4)
    write_cfg(mk(5, 3, 1, 32'h0));
    start_run();
    expect_phase(1'b0, len_f(5, 1), "R4");
    expect_phase(1'b1, len_f(3, 1), "R3");
    expect_phase(1'b0, len_f(5, 1), "R3");
    expect_phase(1'b1, len_f(3, 1), "R4");
    stop_run();

    // zero divisors: offset only (R7)
    write_cfg(mk(0, 0, 7, 32'h0));
    start_run();
    expect_phase(1'b0, OFF, "R7");
    expect_phase(1'b1, OFF, "R7");
    stop_run();

    // exponent clamp (R6)
    write_cfg(mk(3, 1, 7, 32'h0));
    start_run();
    expect_phase(1'b0, 3 * 32 + OFF, "R6");
    expect_phase(1'b1, 1 * 32 + OFF, "R6");
    stop_run();

    // junk upper bits ignored (R2)
    write_cfg(mk(2, 9, 0, 32'hFFFF_FFFF));
    start_run();
    expect_phase(1'b0, 2 + OFF, "R2");
    expect_phase(1'b1, 9 + OFF, "R2");
    stop_run();

    // write mid-phase applies at next boundary (R8)
    write_cfg(mk(9, 9, 0, 32'h0));
    start_run();
    fork
      expect_phase(1'b0, 9 + OFF, "R8");
      begin
        repeat (3) @(posedge clk);
        write_cfg(mk(2, 6, 1, 32'h0));
      end
    join
    expect_phase(1'b1, len_f(6, 1), "R8");
    expect_phase(1'b0, len_f(2, 1), "R8");
    stop_run();

    // hold during high phase (R9)
    write_cfg(mk(4, 5, 1, 32'h0));
    start_run();
    expect_phase(1'b0, len_f(4, 1), "R9");
    fork
      expect_phase(1'b1, len_f(5, 1) + 3, "R9");
      begin
        @(posedge clk); #1 hold = 1'b1;
        repeat (3) @(posedge clk);
        #1 hold = 1'b0;
      end
    join
    expect_phase(1'b0, len_f(4, 1), "R9");
    stop_run();

    // drop mid-phase, restart fresh (R10)
    write_cfg(mk(5, 5, 1, 32'h0));
    start_run();
    repeat (5) @(negedge clk);
    stop_run();
    start_run();
    expect_phase(1'b0, len_f(5, 1), "R10");
    expect_phase(1'b1, len_f(5, 1), "R10");
    stop_run();

    // random configurations (R2, R3, R6)
    for (int it = 0; it < 10; it++) begin
      int lo = int'($urandom % 64);
      int hi = int'($urandom % 64);
      int e  = int'($urandom % 8);
      logic [31:0] junk = $urandom;
      write_cfg(mk(lo, hi, e, junk));
      start_run();
      expect_phase(1'b0, len_f(lo, e), "R3");
      expect_phase(1'b1, len_f(hi, e), "R3");
      expect_phase(1'b0, len_f(lo, e), "R2");
      stop_run();
    end

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule